// File: doc/BRIEF.md
# Register-Mapped System Timer Unit

This block gives a processor a time base and two periodic or single-shot timeout sources behind one 32-bit word-addressed register port. A free-running 32-bit stamp counter advances on every clock and can be preset by software. Two identical reloadable channels count down from a programmed period. Each channel's control register holds the period in its upper 30 bits and the run and single-shot controls in its two lowest bits, so every period is a multiple of four clocks.

Expiry events from the channels and the stamp wrap land in one sticky flag register. Software clears flags by writing ones. Flag bits 0 and 1 drive the channel interrupt lines directly. Three word addresses are reserved for a watchdog that this unit does not implement: they read as zero and ignore writes. Read data is registered and appears one clock after the address is presented.

Top module: `os_timer_unit`

## Requirements
- R1: After a synchronous reset, both channel counts, both control registers and the flag register read zero, and both interrupt lines are low.
- R2: The stamp counter (word address 0) rises by one on every clock, and a write loads the written value in its place.
- R3: When the stamp counter steps from 0xFFFFFFFF to 0, flag bit 2 is set.
- R4: A control-register write (channel 0 at word 2, channel 1 at word 4) with bit 0 set loads the channel count (word 1 or 3) with the written value with its two lowest bits zeroed. The control register reads back as written.
- R5: With bit 0 = 1 and bit 1 = 0, a channel with period P sets its flag every P clocks and keeps running. Its count reads P minus (clocks since the write, modulo P).
- R6: With bit 0 = 1 and bit 1 = 1, a channel sets its flag once, P clocks after the write. Its count then stays 0 and its control register reads back with bit 0 cleared.
- R7: Writing zero to a control register stops the channel. Its count holds and it raises no further flags.
- R8: The flag register is at word address 8: bit 0 is channel 0, bit 1 is channel 1, bit 2 is the stamp wrap, and bit 3 always reads 0. Writing a 1 to a bit clears it, and writing a 0 leaves it unchanged. The output irq_tmr0 follows bit 0 and irq_tmr1 follows bit 1.
- R9: If a flag's set event and a clearing write fall in the same clock, the flag stays set.
- R10: Word addresses 5, 6 and 7 read zero and ignore writes. Read data appears on bus_rdata one clock after bus_addr is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Word address |
| bus_we | input | 1 | Write strobe for the current word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq_tmr0 | output | 1 | Channel 0 interrupt, high while flag bit 0 is set |
| irq_tmr1 | output | 1 | Channel 1 interrupt, high while flag bit 1 is set |

## Verification
The channel countdown is tried with a table of control words. The table covers several periods, an odd period word whose low bits must be dropped, a zero-wait readback, and a single-shot word read well after expiry. Each entry gives a distinct count value, so an off-by-one in the expiry point or a wrong reload value shows up at once. Directed runs time the exact interrupt edge of a repeating channel over two periods, and a single-shot run shows there is no second event. Further runs place a clearing write on the very clock of an expiry, take the stamp counter across its wrap, and show that zero-bit writes and writes to other bits leave a pending flag in place.

// File: rtl/ostmr_pkg.sv
package ostmr_pkg;
  localparam int NUM_CH   = 2;
  localparam int FLAG_W   = 4;
  localparam int FLAG_TS  = 2;
  localparam int FLAG_WD  = 3;
  localparam int WA_STAMP = 0;
  localparam int WA_FLAGS = 8;
  // Channel i: count at 1+2i, control at 2+2i
  function automatic int cnt_addr(input int ch);
    return 1 + 2 * ch;
  endfunction
  function automatic int ctl_addr(input int ch);
    return 2 + 2 * ch;
  endfunction
endpackage

// File: rtl/ostmr_stamp.sv
module ostmr_stamp #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] value,
  output logic         wrap
);
  always_ff @(posedge clk) begin
    if (rst)     value <= '0;
    else if (ld) value <= ld_val;
    else         value <= value + W'(1);
  end

  assign wrap = (value == '1) && !ld;

  assert_stamp_step_R2: assert property (@(posedge clk) disable iff (rst)
    !ld |=> value == $past(value) + W'(1));
  assert_stamp_load_R2: assert property (@(posedge clk) disable iff (rst)
    ld |=> value == $past(ld_val));
endmodule

// File: rtl/ostmr_chan.sv
module ostmr_chan #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cnt_we,
  input  logic         ctl_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] count,
  output logic [W-1:0] ctl,
  output logic         expire
);
  logic         run;
  logic         single;
  logic [W-1:0] period;

  assign run    = ctl[0];
  assign single = ctl[1];
  assign period = {ctl[W-1:2], 2'b00};
  assign expire = run && (count <= W'(1)) && !ctl_we && !cnt_we;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      ctl   <= '0;
    end else if (ctl_we) begin
      ctl <= wdata;
      if (wdata[0]) count <= {wdata[W-1:2], 2'b00};
    end else if (cnt_we) begin
      count <= wdata;
    end else if (run) begin
      if (count <= W'(1)) begin
        if (single) begin
          count  <= '0;
          ctl[0] <= 1'b0;
        end else begin
          count <= period;
        end
      end else begin
        count <= count - W'(1);
      end
    end
  end

  assert_arm_load_R4: assert property (@(posedge clk) disable iff (rst)
    ctl_we && wdata[0] |=> count == {$past(wdata[W-1:2]), 2'b00});
  assert_repeat_reload_R5: assert property (@(posedge clk) disable iff (rst)
    expire && !single |=> run && count == $past(period));
  assert_single_stop_R6: assert property (@(posedge clk) disable iff (rst)
    expire && single |=> !run && count == '0);
  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !run && !ctl_we && !cnt_we |=> $stable(count));
endmodule

// File: rtl/ostmr_flags.sv
module ostmr_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic         clr_we,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] flags
);
  logic [N-1:0] clr_eff;
  assign clr_eff = clr_we ? clr_mask : '0;

  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= (flags & ~clr_eff) | set;
  end

  for (genvar b = 0; b < N; b++) begin : g_chk
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
      set[b] |=> flags[b]);
    assert_w1c_R8: assert property (@(posedge clk) disable iff (rst)
      clr_we && clr_mask[b] && !set[b] |=> !flags[b]);
    assert_zero_keeps_R8: assert property (@(posedge clk) disable iff (rst)
      flags[b] && !clr_eff[b] |=> flags[b]);
  end
endmodule

// File: rtl/os_timer_unit.sv
module os_timer_unit
  import ostmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_tmr0,
  output logic              irq_tmr1
);
  localparam logic [ADDR_W-1:0] A_STAMP = ADDR_W'(WA_STAMP);
  localparam logic [ADDR_W-1:0] A_FLAGS = ADDR_W'(WA_FLAGS);

  logic [DATA_W-1:0] stamp_val;
  logic              stamp_wrap;
  logic              stamp_we;
  logic [DATA_W-1:0] ch_count [NUM_CH];
  logic [DATA_W-1:0] ch_ctl   [NUM_CH];
  logic [NUM_CH-1:0] ch_expire;
  logic [FLAG_W-1:0] flag_set;
  logic [FLAG_W-1:0] flags;
  logic              flags_we;
  logic [DATA_W-1:0] rd_next;

  assign stamp_we = bus_we && (bus_addr == A_STAMP);
  assign flags_we = bus_we && (bus_addr == A_FLAGS);

  ostmr_stamp #(.W(DATA_W)) u_stamp (
    .clk(clk), .rst(rst), .ld(stamp_we), .ld_val(bus_wdata),
    .value(stamp_val), .wrap(stamp_wrap)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic cnt_we_i;
    logic ctl_we_i;
    assign cnt_we_i = bus_we && (bus_addr == ADDR_W'(cnt_addr(i)));
    assign ctl_we_i = bus_we && (bus_addr == ADDR_W'(ctl_addr(i)));
    ostmr_chan #(.W(DATA_W)) u_chan (
      .clk(clk), .rst(rst), .cnt_we(cnt_we_i), .ctl_we(ctl_we_i),
      .wdata(bus_wdata), .count(ch_count[i]), .ctl(ch_ctl[i]),
      .expire(ch_expire[i])
    );
  end

  always_comb begin
    flag_set           = '0;
    flag_set[NUM_CH-1:0] = ch_expire;
    flag_set[FLAG_TS]  = stamp_wrap;
    flag_set[FLAG_WD]  = 1'b0;
  end

  ostmr_flags #(.N(FLAG_W)) u_flags (
    .clk(clk), .rst(rst), .set(flag_set), .clr_we(flags_we),
    .clr_mask(bus_wdata[FLAG_W-1:0]), .flags(flags)
  );

  always_comb begin
    rd_next = '0;
    if (bus_addr == A_STAMP) rd_next = stamp_val;
    if (bus_addr == A_FLAGS) rd_next = DATA_W'(flags);
    for (int i = 0; i < NUM_CH; i++) begin
      if (bus_addr == ADDR_W'(cnt_addr(i))) rd_next = ch_count[i];
      if (bus_addr == ADDR_W'(ctl_addr(i))) rd_next = ch_ctl[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end

  assign irq_tmr0 = flags[0];
  assign irq_tmr1 = flags[1];

  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == ADDR_W'(5) || bus_addr == ADDR_W'(6) || bus_addr == ADDR_W'(7))
      |=> bus_rdata == '0);
  assert_wrap_flag_R3: assert property (@(posedge clk) disable iff (rst)
    stamp_val == '1 && !stamp_we |=> flags[FLAG_TS]);
  assert_wd_flag_zero_R8: assert property (@(posedge clk) disable iff (rst)
    !flags[FLAG_WD]);
endmodule

// File: tb/test_os_timer_unit.sv
module test_os_timer_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 5;
  // {control word written to channel 0, idle clocks, expected count}
  localparam logic [95:0] VEC [NV] = '{
    {32'h0000_0011, 32'd5,  32'd11},
    {32'h0000_0013, 32'd20, 32'd0},
    {32'h0000_0017, 32'd3,  32'd17},
    {32'h0000_0009, 32'd19, 32'd5},
    {32'h0000_0101, 32'd0,  32'd256}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_tmr0, irq_tmr1;
  int          n_chk = 0;
  int          n_fail = 0;
  logic [31:0] v, v2;

  always #(CLK_PERIOD/2) clk = ~clk;

  os_timer_unit i_os_timer_unit (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_tmr0(irq_tmr0), .irq_tmr1(irq_tmr1)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    bus_addr = 4'(a); bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    bus_addr = 4'(a);
    @(negedge clk);
    d = bus_rdata;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(1, v); chk("R1 count0", v, 0);
    rd(2, v); chk("R1 ctl0", v, 0);
    rd(3, v); chk("R1 count1", v, 0);
    rd(4, v); chk("R1 ctl1", v, 0);
    rd(8, v); chk("R1 flags", v, 0);
    chk("R1 irqs", {30'd0, irq_tmr1, irq_tmr0}, 0);

    // R10 reserved words
    for (int a = 5; a < 8; a++) begin
      wr(a, 32'hFFFF_FFFF);
      rd(a, v); chk("R10 reserved reads zero", v, 0);
    end
    rd(8, v); chk("R10 reserved write no effect on flags", v, 0);

    // R2 stamp load and step
    wr(0, 32'd100); rd(0, v); chk("R2 stamp load", v, 100);
    wr(0, 32'd100); idle(7); rd(0, v); chk("R2 stamp step", v, 107);

    // R3 wrap
    wr(0, 32'hFFFF_FFFD); idle(2);
    rd(8, v); chk("R3 no flag before wrap", v & 32'h4, 0);
    rd(8, v); chk("R3 flag after wrap", v & 32'h4, 32'h4);
    wr(8, 32'h4); rd(8, v); chk("R8 clear stamp flag", v & 32'h4, 0);

    // R4/R5/R6 vector table on channel 0
    for (int i = 0; i < NV; i++) begin
      wr(2, VEC[i][95:64]);
      idle(int'(VEC[i][63:32]));
      rd(1, v); chk("R4/R5/R6 table count", v, VEC[i][31:0]);
      wr(2, 0); wr(8, 32'h1);
    end
    wr(2, 32'h0000_0017); rd(2, v); chk("R4 ctl readback", v, 32'h17);
    wr(2, 0); wr(8, 32'h1);

    // R5 periodic on channel 1, P = 16
    wr(4, 32'h0000_0011); idle(15);
    chk("R5 no irq before period", irq_tmr1, 0);
    idle(1); chk("R5 irq at period", irq_tmr1, 1);
    rd(8, v); chk("R8 flag bit1", v & 32'h3, 32'h2);
    chk("R8 irq0 idle", irq_tmr0, 0);
    wr(8, 32'h2); chk("R8 w1c", irq_tmr1, 0);
    idle(13); chk("R5 no irq early second", irq_tmr1, 0);
    idle(1); chk("R5 irq second period", irq_tmr1, 1);
    wr(8, 32'h0); chk("R8 zero write keeps", irq_tmr1, 1);
    wr(8, 32'h1); chk("R8 other bit keeps", irq_tmr1, 1);
    idle(13);
    wr(8, 32'h2); chk("R9 set beats clear", irq_tmr1, 1);
    wr(8, 32'h2); chk("R9 later clear", irq_tmr1, 0);

    // R7 disable
    wr(4, 0); wr(8, 32'h2);
    rd(3, v); idle(40); rd(3, v2);
    chk("R7 count held", v2, v);
    chk("R7 no irq", irq_tmr1, 0);

    // R6 single shot on channel 0, P = 8
    wr(2, 32'h0000_000B); idle(7);
    chk("R6 no irq early", irq_tmr0, 0);
    idle(1); chk("R6 irq once", irq_tmr0, 1);
    rd(2, v); chk("R6 run bit cleared", v, 32'hA);
    rd(1, v); chk("R6 count zero", v, 0);
    wr(8, 32'h1); idle(20);
    chk("R6 no second event", irq_tmr0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule